// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target

This block models the target side of a three-wire serial EEPROM. A host drives chip select, a serial clock and a serial data input. The target answers on a serial data output with a separate output-enable, so the output can be tri-stated outside the block. All three serial inputs are brought into the system clock domain through two-flop synchronizers. Edges are then detected on the system clock. The storage holds 1024 words of 16 bits. A static strap input `org_wide` can instead present the same storage as 2048 bytes.

The host frames an instruction as a start bit, a two-bit opcode and an address. Writes also carry a data field. The block supports single and sequential reads, single-location erase and write, and whole-array erase and write. Two special instructions set and clear a write-enable latch. Modifying instructions also need the `prog_en` input to be high. A modifying operation begins when chip select falls and then runs for a parameterised number of system clocks. While it runs, the host can raise chip select again and poll busy/ready on the data output.

Top module: `eeprom_target`

## Requirements
- R1: An instruction is a 1 start bit, a 2-bit opcode and an address, sent MSB first. Opcodes are 10 read, 01 write, 11 erase and 00 special. Each bit is sampled on a rising serial clock edge. The address is 10 bits when `org_wide`=1 and 11 bits when `org_wide`=0. A write carries 16 data bits in the wide mode and 8 in the byte mode. Zeros before the start bit are ignored.
- R2: For opcode 00, the two most significant address bits choose the operation: 11 sets the write-enable latch, 00 clears it, 10 fills every location with ones, and 01 fills every location with the following data field. Setting and clearing the latch works whatever the level of `prog_en`.
- R3: After reset, the output enable is low and the write-enable latch is clear. While the latch is clear, write, erase and both fill instructions are discarded and no busy cycle starts.
- R4: On a read, the output enable rises once the last address bit is sampled, and a single 0 bit is driven first. The addressed data then follows MSB first, one bit per rising serial clock edge.
- R5: While chip select stays high and clocks continue, a read moves on to the next address with no leading 0. It wraps from the last address (1023 wide, 2047 byte mode) to 0.
- R6: A write or erase takes effect on the falling edge of chip select. This needs the complete instruction, the latch set and `prog_en` high when the instruction was decoded; otherwise nothing happens. An erase sets every bit of the location to 1. A write replaces the old contents without a prior erase.
- R7: When chip select rises after a modifying operation has started, the output is enabled. It drives 0 for BUSY_CYCLES system clocks from the start of the operation and 1 afterwards.
- R8: While status is shown, a 1 sampled on a rising serial clock edge turns the output enable off after the next falling serial clock edge. If the target is ready, that 1 is also taken as a start bit.
- R9: An instruction sent while a modifying operation is still running is discarded and changes no location.
- R10: In byte mode, byte address a selects word a>>1. Bit a[0]=1 selects the upper byte and bit a[0]=0 the lower byte; a byte write leaves the other byte of the word unchanged.
- R11: While chip select is low, the output enable is low. A partially received instruction is discarded when chip select falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| org_wide | input | 1 | Organisation strap: 1 = 16-bit words, 0 = bytes |
| prog_en | input | 1 | Program enable for modifying instructions |
| ser_cs | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Serial data into the target |
| ser_dout | output | 1 | Serial data out (read data or busy/ready) |
| ser_dout_oe | output | 1 | Output enable for ser_dout |

## Verification
A serial input edge reaches the output registers on the third system clock edge after it changes: two synchronizer stages, then the registered edge detect and the update. Each serial clock phase lasts eight system clocks. The bench samples outputs six cycles after a rising serial edge and after the following falling edge, so every result is settled and none is yet overwritten. A modifying operation starts three clocks after chip select falls. Busy is therefore checked about thirty cycles after that point, and ready is checked more than BUSY_CYCLES cycles later, clear of the transition on both sides.

// File: rtl/eeprom_pkg.sv
// Shared encodings for the serial EEPROM target.
// Assumes: opcode and sub-operation values are fixed by the serial protocol.
package eeprom_pkg;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_ERASE = 2'b11;
    localparam logic [1:0] OPC_SPEC  = 2'b00;

    localparam logic [1:0] SUB_LATCH_ON  = 2'b11;
    localparam logic [1:0] SUB_LATCH_OFF = 2'b00;
    localparam logic [1:0] SUB_FILL_ONES = 2'b10;
    localparam logic [1:0] SUB_FILL_DATA = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_READ,
        ST_SKIP
    } ctl_state_t;

    typedef enum logic [2:0] {
        P_NONE,
        P_WRITE,
        P_ERASE,
        P_FILL1,
        P_FILLD
    } pend_op_t;

endpackage

// File: rtl/eeprom_sync.sv
// Two-flop synchronizer for a vector of asynchronous single-bit inputs.
// Assumes: each bit is independent; no bus coherency is needed.
module eeprom_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] s1;
    logic [N-1:0] s2;

    // Two register stages between the pins and the logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= d;
            s2 <= s1;
        end
    end

    assign q = s2;
endmodule

// File: rtl/eeprom_array.sv
// Storage array of 2**WORD_AW words of 16 bits, with a byte view.
// Assumes: the contents are not reset; the read port is combinational;
// a fill writes every word in one cycle.
module eeprom_array #(
    parameter int WORD_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wide,
    input  logic [WORD_AW:0]   rd_addr,
    output logic [15:0]        rd_data,
    input  logic               wr_en,
    input  logic               wr_all,
    input  logic [WORD_AW:0]   wr_addr,
    input  logic [15:0]        wr_data
);
    localparam int DEPTH   = 1 << WORD_AW;
    localparam int BYTE_AW = WORD_AW + 1;

    logic [15:0] mem [DEPTH];
    logic [15:0] rd_word;
    logic [15:0] fill;

    // Select the word, then the byte in byte mode.
    always_comb begin
        rd_word = mem[wide ? rd_addr[WORD_AW-1:0] : rd_addr[BYTE_AW-1:1]];
        if (wide) rd_data = rd_word;
        else      rd_data = {8'h00, rd_addr[0] ? rd_word[15:8] : rd_word[7:0]};
    end

    // In byte mode a fill copies the byte into both halves of each word.
    assign fill = wide ? wr_data : {wr_data[7:0], wr_data[7:0]};

    // Single-location write, or fill of every location.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            if (wr_all) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= fill;
            end else if (wide) begin
                mem[wr_addr[WORD_AW-1:0]] <= wr_data;
            end else if (wr_addr[0]) begin
                mem[wr_addr[BYTE_AW-1:1]][15:8] <= wr_data[7:0];
            end else begin
                mem[wr_addr[BYTE_AW-1:1]][7:0] <= wr_data[7:0];
            end
        end
    end

    assert_fill_reaches_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_all && wide) |=> (mem[0] == $past(wr_data) && mem[DEPTH-1] == $past(wr_data)));
endmodule

// File: rtl/eeprom_ctrl.sv
// Protocol engine: edge detection, instruction shifter, decode, read
// streaming, write-enable latch, self-timed busy and status output.
// Assumes: cs_s, sk_s and din_s are already synchronized; wide and prog_en
// are steady during an instruction; the serial clock is much slower than clk.
module eeprom_ctrl
    import eeprom_pkg::*;
#(
    parameter int WORD_AW     = 10,
    parameter int BUSY_CYCLES = 5000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide,
    input  logic             prog_en,
    input  logic             cs_s,
    input  logic             sk_s,
    input  logic             din_s,
    input  logic [15:0]      rd_data,
    output logic [WORD_AW:0] rd_addr,
    output logic             wr_en,
    output logic             wr_all,
    output logic [WORD_AW:0] wr_addr,
    output logic [15:0]      wr_data,
    output logic             dout,
    output logic             dout_oe
);
    localparam int AW16   = WORD_AW;
    localparam int AW8    = WORD_AW + 1;
    localparam int HDR16  = AW16 + 2;
    localparam int HDR8   = AW8 + 2;
    localparam int FULL16 = HDR16 + 16;
    localparam int FULL8  = HDR8 + 8;
    localparam int CW     = AW16 + 16;
    localparam int CNT_W  = $clog2(FULL16 + 1);
    localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

    logic cs_d, sk_d;
    logic cs_rise, cs_fall, sk_rise, sk_fall;

    ctl_state_t        state;
    logic [CW-2:0]     cmd;
    logic [CW-1:0]     cmd_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx, hdr_len, full_len;
    logic              data_phase;
    logic [1:0]        op_r;
    logic              wen_r;
    pend_op_t          pend_op;
    logic [AW8-1:0]    pend_addr;
    logic [15:0]       pend_data;
    logic [AW8-1:0]    addr_r, addr_inc;
    logic [3:0]        idx, dw_top;
    logic              rd_bit, read_on, status_on, status_req, rel_pend;
    logic [BUSY_W-1:0] busy_cnt;
    logic              busy, can_modify, launch;
    logic [1:0]        hdr_op, hdr_sub;
    logic [AW8-1:0]    hdr_addr, full_addr;
    logic [15:0]       full_data;

    // Delay the synchronized levels by one clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_d <= 1'b0;
            sk_d <= 1'b0;
        end else begin
            cs_d <= cs_s;
            sk_d <= sk_s;
        end
    end

    assign cs_rise = cs_s & ~cs_d;
    assign cs_fall = ~cs_s & cs_d;
    assign sk_rise = sk_s & ~sk_d;
    assign sk_fall = ~sk_s & sk_d;

    // Field extraction from the shifter, including the bit arriving now.
    always_comb begin
        cmd_nx     = {cmd, din_s};
        cnt_nx     = cnt + CNT_W'(1);
        hdr_len    = wide ? CNT_W'(HDR16) : CNT_W'(HDR8);
        full_len   = wide ? CNT_W'(FULL16) : CNT_W'(FULL8);
        hdr_op     = wide ? cmd_nx[AW16+1 -: 2] : cmd_nx[AW8+1 -: 2];
        hdr_sub    = wide ? cmd_nx[AW16-1 -: 2] : cmd_nx[AW8-1 -: 2];
        hdr_addr   = wide ? {1'b0, cmd_nx[AW16-1:0]} : cmd_nx[AW8-1:0];
        full_addr  = wide ? {1'b0, cmd_nx[16 +: AW16]} : cmd_nx[8 +: AW8];
        full_data  = wide ? cmd_nx[15:0] : {8'h00, cmd_nx[7:0]};
        dw_top     = wide ? 4'd15 : 4'd7;
        addr_inc   = wide ? {1'b0, addr_r[AW16-1:0] + AW16'(1)} : addr_r + AW8'(1);
        busy       = (busy_cnt != '0);
        can_modify = wen_r & prog_en;
        launch     = cs_fall && (pend_op != P_NONE);
    end

    // The array update fires in the same cycle that the operation starts.
    assign wr_en   = launch;
    assign wr_all  = (pend_op == P_FILL1) || (pend_op == P_FILLD);
    assign wr_addr = pend_addr;
    assign wr_data = ((pend_op == P_ERASE) || (pend_op == P_FILL1)) ? 16'hFFFF : pend_data;
    assign rd_addr = addr_r;

    assign dout    = status_on ? ~busy : rd_bit;
    assign dout_oe = status_on | read_on;

    // Self-timed busy counter, loaded when an operation starts.
    always_ff @(posedge clk) begin
        if (!rst_n)      busy_cnt <= '0;
        else if (launch) busy_cnt <= BUSY_W'(BUSY_CYCLES);
        else if (busy)   busy_cnt <= busy_cnt - BUSY_W'(1);
    end

    // Serial protocol sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cmd        <= '0;
            cnt        <= '0;
            data_phase <= 1'b0;
            op_r       <= 2'b00;
            wen_r      <= 1'b0;
            pend_op    <= P_NONE;
            pend_addr  <= '0;
            pend_data  <= '0;
            addr_r     <= '0;
            idx        <= '0;
            rd_bit     <= 1'b0;
            read_on    <= 1'b0;
            status_on  <= 1'b0;
            status_req <= 1'b0;
            rel_pend   <= 1'b0;
        end else if (!cs_s) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            data_phase <= 1'b0;
            read_on    <= 1'b0;
            status_on  <= 1'b0;
            rel_pend   <= 1'b0;
            if (cs_fall) begin
                if (pend_op != P_NONE) status_req <= 1'b1;
                pend_op <= P_NONE;
            end
        end else begin
            if (cs_rise) status_on <= busy | status_req;
            if (sk_fall && rel_pend) begin
                status_on  <= 1'b0;
                status_req <= 1'b0;
                rel_pend   <= 1'b0;
            end
            if (sk_rise) begin
                unique case (state)
                    ST_IDLE: begin
                        if (din_s) begin
                            if (status_on) rel_pend <= 1'b1;
                            if (busy) begin
                                state <= ST_SKIP;
                            end else begin
                                state      <= ST_CMD;
                                cnt        <= '0;
                                data_phase <= 1'b0;
                            end
                        end
                    end
                    ST_CMD: begin
                        cmd <= cmd_nx[CW-2:0];
                        cnt <= cnt_nx;
                        if (!data_phase && cnt_nx == hdr_len) begin
                            op_r   <= hdr_op;
                            addr_r <= hdr_addr;
                            unique case (hdr_op)
                                OPC_READ: begin
                                    state   <= ST_READ;
                                    read_on <= 1'b1;
                                    rd_bit  <= 1'b0;
                                    idx     <= dw_top;
                                end
                                OPC_WRITE: data_phase <= 1'b1;
                                OPC_ERASE: begin
                                    state <= ST_SKIP;
                                    if (can_modify) begin
                                        pend_op   <= P_ERASE;
                                        pend_addr <= hdr_addr;
                                    end
                                end
                                default: begin
                                    unique case (hdr_sub)
                                        SUB_LATCH_ON: begin
                                            wen_r <= 1'b1;
                                            state <= ST_SKIP;
                                        end
                                        SUB_LATCH_OFF: begin
                                            wen_r <= 1'b0;
                                            state <= ST_SKIP;
                                        end
                                        SUB_FILL_ONES: begin
                                            state <= ST_SKIP;
                                            if (can_modify) pend_op <= P_FILL1;
                                        end
                                        default: data_phase <= 1'b1;
                                    endcase
                                end
                            endcase
                        end else if (data_phase && cnt_nx == full_len) begin
                            state <= ST_SKIP;
                            if (can_modify) begin
                                pend_op   <= (op_r == OPC_WRITE) ? P_WRITE : P_FILLD;
                                pend_addr <= full_addr;
                                pend_data <= full_data;
                            end
                        end
                    end
                    ST_READ: begin
                        rd_bit <= rd_data[idx];
                        if (idx == 4'd0) begin
                            idx    <= dw_top;
                            addr_r <= addr_inc;
                        end else begin
                            idx <= idx - 4'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_quiet_when_deselected_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !dout_oe);
    assert_pending_needs_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_op != P_NONE) |-> wen_r);
    assert_start_on_cs_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_fall));
    assert_busy_blocks_decode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state != ST_CMD && !read_on));
    assert_read_leads_with_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(read_on) |-> (dout_oe && !dout));
    assert_single_output_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({status_on, read_on}));
endmodule

// File: rtl/eeprom_target.sv
// Top of the serial EEPROM target: synchronizers, protocol engine, array.
// Assumes: org_wide and prog_en are static straps relative to an
// instruction; ser_dout_oe drives an external tri-state buffer.
module eeprom_target #(
    parameter int WORD_AW     = 10,
    parameter int BUSY_CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic org_wide,
    input  logic prog_en,
    input  logic ser_cs,
    input  logic ser_clk,
    input  logic ser_din,
    output logic ser_dout,
    output logic ser_dout_oe
);
    logic [2:0]       sync_q;
    logic [WORD_AW:0] rd_addr, wr_addr;
    logic [15:0]      rd_data, wr_data;
    logic             wr_en, wr_all;

    eeprom_sync #(.N(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_cs, ser_clk, ser_din}),
        .q     (sync_q)
    );

    eeprom_ctrl #(.WORD_AW(WORD_AW), .BUSY_CYCLES(BUSY_CYCLES)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide    (org_wide),
        .prog_en (prog_en),
        .cs_s    (sync_q[2]),
        .sk_s    (sync_q[1]),
        .din_s   (sync_q[0]),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (ser_dout),
        .dout_oe (ser_dout_oe)
    );

    eeprom_array #(.WORD_AW(WORD_AW)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wide    (org_wide),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );
endmodule

// File: tb/sim_eeprom_target.sv
// Directed bench for the serial EEPROM target.
module sim_eeprom_target;
    localparam int BUSY = 200;
    localparam logic [1:0] OP_RD = 2'b10, OP_WR = 2'b01, OP_ER = 2'b11, OP_SP = 2'b00;

    logic clk = 1'b0, rst_n = 1'b0;
    logic org_wide = 1'b1, prog_en = 1'b1;
    logic cs = 1'b0, sk = 1'b0, din = 1'b0;
    logic dout, dout_oe;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic s_oe, last_o, rd_dummy, rd_dummy_oe;
    logic [15:0] rd_words [4];

    eeprom_target #(.WORD_AW(10), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .prog_en(prog_en),
        .ser_cs(cs), .ser_clk(sk), .ser_din(din),
        .ser_dout(dout), .ser_dout_oe(dout_oe)
    );

    always #10 clk = ~clk;

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic sk_bit(input logic b, output logic o);
        din = b;
        wait_clk(8);
        sk = 1'b1;
        wait_clk(6);
        o = dout;
        s_oe = dout_oe;
        wait_clk(2);
        sk = 1'b0;
    endtask

    task automatic select();
        cs = 1'b1;
        wait_clk(8);
    endtask

    task automatic deselect();
        din = 1'b0;
        wait_clk(8);
        cs = 1'b0;
        wait_clk(8);
    endtask

    function automatic logic [10:0] sub_addr(input logic [1:0] s);
        return org_wide ? {1'b0, s, 8'h00} : {s, 9'h000};
    endfunction

    task automatic send(input logic [1:0] op, input logic [10:0] a, input logic [15:0] d, input bit with_d);
        int aw = org_wide ? 10 : 11;
        int dw = org_wide ? 16 : 8;
        logic o;
        sk_bit(1'b1, o);
        sk_bit(op[1], o);
        sk_bit(op[0], o);
        for (int i = aw - 1; i >= 0; i--) sk_bit(a[i], o);
        if (with_d) for (int i = dw - 1; i >= 0; i--) sk_bit(d[i], o);
        last_o = o;
    endtask

    task automatic instr(input logic [1:0] op, input logic [10:0] a, input logic [15:0] d, input bit with_d);
        select();
        send(op, a, d, with_d);
        deselect();
    endtask

    task automatic write_wait(input logic [10:0] a, input logic [15:0] d);
        instr(OP_WR, a, d, 1'b1);
        wait_clk(BUSY + 30);
    endtask

    task automatic read_seq(input logic [10:0] a, input int n);
        int dw = org_wide ? 16 : 8;
        logic o;
        select();
        send(OP_RD, a, 16'h0, 1'b0);
        rd_dummy = last_o;
        rd_dummy_oe = s_oe;
        for (int w = 0; w < n; w++) begin
            rd_words[w] = '0;
            for (int b = 0; b < dw; b++) begin
                sk_bit(1'b0, o);
                rd_words[w] = {rd_words[w][14:0], o};
            end
        end
        deselect();
    endtask

    task automatic probe_no_status(input string tag);
        wait_clk(30);
        select();
        check(tag, {31'b0, dout_oe}, 32'd0);
        deselect();
    endtask

    task automatic t_reset();
        check("R3 output enable low after reset", {31'b0, dout_oe}, 32'd0);
        instr(OP_WR, 11'd5, 16'h1234, 1'b1);
        probe_no_status("R3 write with latch clear starts nothing");
    endtask

    task automatic t_write_status();
        logic o;
        instr(OP_SP, sub_addr(2'b11), 16'h0, 1'b0);
        instr(OP_WR, 11'd3, 16'hA5C3, 1'b1);
        wait_clk(20);
        select();
        check("R7 busy status enabled", {31'b0, dout_oe}, 32'd1);
        check("R7 busy status level", {31'b0, dout}, 32'd0);
        wait_clk(BUSY + 20);
        check("R7 ready status level", {31'b0, dout}, 32'd1);
        sk_bit(1'b1, o);
        wait_clk(6);
        check("R8 output released after 1 shifted", {31'b0, dout_oe}, 32'd0);
        deselect();
    endtask

    task automatic t_read();
        read_seq(11'd3, 1);
        check("R4 dummy bit enabled", {31'b0, rd_dummy_oe}, 32'd1);
        check("R4 dummy bit is 0", {31'b0, rd_dummy}, 32'd0);
        check("R4 word data", {16'b0, rd_words[0]}, 32'h0000A5C3);
    endtask

    task automatic t_seq_wrap();
        write_wait(11'd1023, 16'h8001);
        write_wait(11'd0, 16'h1357);
        read_seq(11'd1023, 2);
        check("R5 first word at top address", {16'b0, rd_words[0]}, 32'h00008001);
        check("R5 wrapped word, no dummy", {16'b0, rd_words[1]}, 32'h00001357);
    endtask

    task automatic t_erase_overwrite();
        instr(OP_ER, 11'd3, 16'h0, 1'b0);
        wait_clk(BUSY + 30);
        read_seq(11'd3, 1);
        check("R6 erase gives all ones", {16'b0, rd_words[0]}, 32'h0000FFFF);
        write_wait(11'd0, 16'h00F0);
        read_seq(11'd0, 1);
        check("R6 write replaces without erase", {16'b0, rd_words[0]}, 32'h000000F0);
    endtask

    task automatic t_prog_en();
        prog_en = 1'b0;
        instr(OP_WR, 11'd3, 16'h0000, 1'b1);
        probe_no_status("R6 prog_en low starts nothing");
        prog_en = 1'b1;
        read_seq(11'd3, 1);
        check("R6 prog_en low leaves data", {16'b0, rd_words[0]}, 32'h0000FFFF);
    endtask

    task automatic t_latch();
        instr(OP_SP, sub_addr(2'b00), 16'h0, 1'b0);
        instr(OP_WR, 11'd3, 16'h0000, 1'b1);
        probe_no_status("R2 write after latch cleared starts nothing");
        read_seq(11'd3, 1);
        check("R2 latch cleared blocks write", {16'b0, rd_words[0]}, 32'h0000FFFF);
        prog_en = 1'b0;
        instr(OP_SP, sub_addr(2'b11), 16'h0, 1'b0);
        prog_en = 1'b1;
        write_wait(11'd3, 16'h0BAD);
        read_seq(11'd3, 1);
        check("R2 latch set with prog_en low", {16'b0, rd_words[0]}, 32'h00000BAD);
    endtask

    task automatic t_busy_ignore();
        instr(OP_WR, 11'd10, 16'h1111, 1'b1);
        wait_clk(20);
        select();
        send(OP_WR, 11'd3, 16'h0000, 1'b1);
        check("R8 output released while busy", {31'b0, s_oe}, 32'd0);
        deselect();
        wait_clk(BUSY + 30);
        read_seq(11'd3, 1);
        check("R9 instruction during busy discarded", {16'b0, rd_words[0]}, 32'h00000BAD);
        read_seq(11'd10, 1);
        check("R9 running write completed", {16'b0, rd_words[0]}, 32'h00001111);
    endtask

    task automatic t_fill();
        instr(OP_SP, sub_addr(2'b10), 16'h0, 1'b0);
        wait_clk(BUSY + 30);
        read_seq(11'd1023, 2);
        check("R2 fill ones top", {16'b0, rd_words[0]}, 32'h0000FFFF);
        check("R2 fill ones bottom", {16'b0, rd_words[1]}, 32'h0000FFFF);
        instr(OP_SP, sub_addr(2'b01), 16'h4242, 1'b1);
        wait_clk(BUSY + 30);
        read_seq(11'd500, 1);
        check("R2 fill data", {16'b0, rd_words[0]}, 32'h00004242);
    endtask

    task automatic t_bytes();
        org_wide = 1'b0;
        write_wait(11'd7, 16'h005A);
        read_seq(11'd6, 2);
        check("R10 lower byte untouched", {16'b0, rd_words[0]}, 32'h00000042);
        check("R10 upper byte written", {16'b0, rd_words[1]}, 32'h0000005A);
        write_wait(11'd2047, 16'h0081);
        read_seq(11'd2047, 2);
        check("R5 byte top address", {16'b0, rd_words[0]}, 32'h00000081);
        check("R5 byte wrap to 0", {16'b0, rd_words[1]}, 32'h00000042);
    endtask

    task automatic t_framing();
        logic o;
        int dw = org_wide ? 16 : 8;
        logic [15:0] w = '0;
        select();
        sk_bit(1'b0, o);
        sk_bit(1'b0, o);
        send(OP_RD, 11'd7, 16'h0, 1'b0);
        for (int b = 0; b < dw; b++) begin
            sk_bit(1'b0, o);
            w = {w[14:0], o};
        end
        check("R1 leading zeros ignored", {16'b0, w}, 32'h0000005A);
        wait_clk(10);
        cs = 1'b0;
        wait_clk(6);
        check("R11 deselect mid-read drops output", {31'b0, dout_oe}, 32'd0);
        wait_clk(10);
        select();
        sk_bit(1'b1, o);
        sk_bit(1'b0, o);
        sk_bit(1'b1, o);
        sk_bit(1'b0, o);
        deselect();
        probe_no_status("R11 partial write discarded");
        read_seq(11'd7, 1);
        check("R11 partial write left data", {16'b0, rd_words[0]}, 32'h0000005A);
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write_status();
        t_read();
        t_seq_wrap();
        t_erase_overwrite();
        t_prog_en();
        t_latch();
        t_busy_ignore();
        t_fill();
        t_bytes();
        t_framing();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule